// File: doc/BRIEF.md
# Fetch-Stage Branch Predictor with Target Table

This block sits beside the program counter of a five-stage 32-bit RISC-V pipeline and guesses, every cycle, where the next fetch should go. It keeps a small direct-mapped table. Each slot holds a one-bit taken flag and a full target address, and the slot is selected by a few low bits of the fetch address. When the slot for the current fetch address says taken, the stored target becomes the next fetch address. The fetched instruction then carries a tag showing that it was fetched down a predicted path. Otherwise the next fetch address is the current one plus four.

Branches are decided in the execute stage. When a branch reaches that stage, the pipeline presents a resolution bundle: the branch PC, its actual direction and target, and the prediction tag and predicted target that travelled down with it. The block writes the actual outcome into the table slot. It compares the outcome with what was predicted and raises a mispredict with a redirect address when they disagree. The redirect takes priority over the fetch-side prediction, so the PC register needs only one next-address input. Flushing the younger instructions is left to the surrounding pipeline.

Top module: `bpred_table`

## Requirements
- R1: After reset every taken flag is clear, so any fetch address gives pred_taken=0, pred_branched=0 and pred_next_pc = fetch_pc + 4.
- R2: The table slot is chosen by fetch_pc[5:2] (16 slots with default parameters). Addresses that differ only in other bits share a slot, for example 0x100 and 0x140.
- R3: When ex_is_branch=1 at a rising clock edge, the slot chosen by ex_pc[5:2] takes flag = ex_taken and target = ex_target. A lookup in that same cycle still sees the old contents, and lookups see the new contents from the next cycle on.
- R4: If the looked-up flag is 1 and there is no mispredict, then pred_taken=1, pred_branched=1 and pred_next_pc equals the stored target.
- R5: If the looked-up flag is 0 and there is no mispredict, then pred_taken=0, pred_branched=0 and pred_next_pc = fetch_pc + 4.
- R6: With ex_is_branch=1, mispredict is 1 whenever ex_pred_taken differs from ex_taken.
- R7: With ex_is_branch=1, ex_taken=1 and ex_pred_taken=1, mispredict is 1 exactly when ex_pred_target differs from ex_target.
- R8: During a mispredict, redirect_pc and pred_next_pc equal ex_target if ex_taken=1, or ex_pc + 4 otherwise, and pred_branched is 0 even when the table predicts taken.
- R9: With ex_is_branch=0, mispredict stays 0 and the table is left unchanged whatever the other execute inputs hold.
- R10: A branch whose direction was predicted correctly (and, if taken, whose target also matched) gives mispredict=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| ex_is_branch | input | 1 | A conditional branch is resolving in execute |
| ex_pc | input | 32 | PC of the resolving branch |
| ex_taken | input | 1 | Actual direction of the resolving branch |
| ex_target | input | 32 | Actual taken target of the resolving branch |
| ex_pred_taken | input | 1 | Prediction tag carried with the resolving branch |
| ex_pred_target | input | 32 | Target that was predicted for the resolving branch |
| pred_taken | output | 1 | Table predicts taken for fetch_pc |
| pred_next_pc | output | 32 | Next fetch address (redirect, predicted target or PC+4) |
| pred_branched | output | 1 | Tag for the fetched instruction: fetched on a predicted-taken path |
| mispredict | output | 1 | Execute outcome disagrees with the prediction; flush needed |
| redirect_pc | output | 32 | Corrected fetch address during a mispredict |

## Verification
The hardest case to reach is a cycle in which a taken slot is being looked up while a wrong-target resolution for the same slot is being written. In that cycle the stale table value, the same-cycle write and the redirect priority all meet at once. The bench first trains slot 0 toward one target. It then resolves the same branch with a different actual target while holding the fetch address on that slot. It checks that the redirect wins and the tag drops, and in the next cycle that the lookup returns the new target. Aliasing is reached by fetching an address 0x40 away from a trained branch.

// File: rtl/bpred_table.sv
module bpred_table #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] fetch_pc,
  input  logic            ex_is_branch,
  input  logic [XLEN-1:0] ex_pc,
  input  logic            ex_taken,
  input  logic [XLEN-1:0] ex_target,
  input  logic            ex_pred_taken,
  input  logic [XLEN-1:0] ex_pred_target,
  output logic            pred_taken,
  output logic [XLEN-1:0] pred_next_pc,
  output logic            pred_branched,
  output logic            mispredict,
  output logic [XLEN-1:0] redirect_pc
);
  localparam int SLOTS = 1 << IDX_W;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic            flag_q [SLOTS];
  logic [XLEN-1:0] tgt_q  [SLOTS];

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic             dir_wrong, tgt_wrong;

  assign rd_idx = fetch_pc[IDX_W+1:2];
  assign wr_idx = ex_pc[IDX_W+1:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        flag_q[i] <= 1'b0;
        tgt_q[i]  <= '0;
      end
    end else if (ex_is_branch) begin
      flag_q[wr_idx] <= ex_taken;
      tgt_q[wr_idx]  <= ex_target;
    end
  end

  assign dir_wrong   = ex_pred_taken != ex_taken;
  assign tgt_wrong   = ex_taken && ex_pred_taken && (ex_pred_target != ex_target);
  assign mispredict  = ex_is_branch && (dir_wrong || tgt_wrong);
  assign redirect_pc = ex_taken ? ex_target : ex_pc + STEP;

  assign pred_taken    = flag_q[rd_idx];
  assign pred_branched = pred_taken && !mispredict;

  always_comb begin
    if (mispredict)      pred_next_pc = redirect_pc;
    else if (pred_taken) pred_next_pc = tgt_q[rd_idx];
    else                 pred_next_pc = fetch_pc + STEP;
  end
endmodule

// File: rtl/bpred_table_chk.sv
module bpred_table_chk #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] fetch_pc,
  input logic            ex_is_branch,
  input logic [XLEN-1:0] ex_pc,
  input logic            ex_taken,
  input logic [XLEN-1:0] ex_target,
  input logic            ex_pred_taken,
  input logic [XLEN-1:0] ex_pred_target,
  input logic            pred_taken,
  input logic [XLEN-1:0] pred_next_pc,
  input logic            pred_branched,
  input logic            mispredict,
  input logic [XLEN-1:0] redirect_pc
);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_is_branch |-> !mispredict);

  assert_tag_needs_pred_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pred_branched |-> pred_taken && !mispredict);

  assert_redirect_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> pred_next_pc == redirect_pc && !pred_branched);

  assert_learn_not_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ex_is_branch && !ex_taken |=>
      (fetch_pc[IDX_W+1:2] != $past(ex_pc[IDX_W+1:2])) || !pred_taken || $past(!rst_n));

  assert_learn_taken_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ex_is_branch && ex_taken |=>
      (fetch_pc[IDX_W+1:2] != $past(ex_pc[IDX_W+1:2])) ||
      (pred_taken && (mispredict || pred_next_pc == $past(ex_target))));

  assert_dir_mismatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ex_is_branch && (ex_taken != ex_pred_taken) |-> mispredict);
endmodule

bind bpred_table bpred_table_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .ex_is_branch(ex_is_branch),
  .ex_pc(ex_pc), .ex_taken(ex_taken), .ex_target(ex_target),
  .ex_pred_taken(ex_pred_taken), .ex_pred_target(ex_pred_target),
  .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
  .pred_branched(pred_branched), .mispredict(mispredict), .redirect_pc(redirect_pc)
);

// File: tb/test_bpred_table.sv
module test_bpred_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        ex_is_branch = 1'b0;
  logic [31:0] ex_pc = '0;
  logic        ex_taken = 1'b0;
  logic [31:0] ex_target = '0;
  logic        ex_pred_taken = 1'b0;
  logic [31:0] ex_pred_target = '0;
  logic        pred_taken, pred_branched, mispredict;
  logic [31:0] pred_next_pc, redirect_pc;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bpred_table i_bpred_table (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .ex_is_branch(ex_is_branch),
    .ex_pc(ex_pc), .ex_taken(ex_taken), .ex_target(ex_target),
    .ex_pred_taken(ex_pred_taken), .ex_pred_target(ex_pred_target),
    .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
    .pred_branched(pred_branched), .mispredict(mispredict), .redirect_pc(redirect_pc)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic ex_set(input logic br, input logic [31:0] pc, input logic tk,
                        input logic [31:0] tg, input logic ptk, input logic [31:0] ptg);
    ex_is_branch = br; ex_pc = pc; ex_taken = tk; ex_target = tg;
    ex_pred_taken = ptk; ex_pred_target = ptg;
  endtask

  task automatic step;
    @(posedge clk); @(negedge clk);
    ex_set(1'b0, '0, 1'b0, '0, 1'b0, '0);
    #1;
  endtask

  task automatic lookup(input string req, input logic [31:0] pc, input logic tk, input logic [31:0] nxt);
    fetch_pc = pc; #1;
    chk(req, "pred_taken", {31'b0, pred_taken}, {31'b0, tk});
    chk(req, "pred_branched", {31'b0, pred_branched}, {31'b0, tk});
    chk(req, "pred_next_pc", pred_next_pc, nxt);
  endtask

  task automatic t_reset_state;
    for (int i = 0; i < 16; i++) lookup("R1", 32'h1000 + 4 * i, 1'b0, 32'h1004 + 4 * i);
    chk("R1", "mispredict", {31'b0, mispredict}, 32'd0);
  endtask

  task automatic t_train_taken;
    fetch_pc = 32'h500;
    ex_set(1'b1, 32'h100, 1'b1, 32'h200, 1'b0, 32'h0); #1;
    chk("R6", "mispredict", {31'b0, mispredict}, 32'd1);
    chk("R8", "redirect_pc", redirect_pc, 32'h200);
    chk("R8", "pred_next_pc", pred_next_pc, 32'h200);
    step();
    lookup("R4", 32'h100, 1'b1, 32'h200);
    lookup("R5", 32'h104, 1'b0, 32'h108);
  endtask

  task automatic t_alias;
    lookup("R2", 32'h140, 1'b1, 32'h200);
    lookup("R2", 32'h7FC0, 1'b1, 32'h200);
    lookup("R2", 32'h13C, 1'b0, 32'h140);
  endtask

  task automatic t_same_cycle;
    fetch_pc = 32'h108;
    ex_set(1'b1, 32'h108, 1'b1, 32'h300, 1'b1, 32'h300); #1;
    chk("R3", "old pred_taken", {31'b0, pred_taken}, 32'd0);
    chk("R10", "mispredict", {31'b0, mispredict}, 32'd0);
    step();
    lookup("R3", 32'h108, 1'b1, 32'h300);
  endtask

  task automatic t_wrong_target;
    fetch_pc = 32'h100;
    ex_set(1'b1, 32'h100, 1'b1, 32'h250, 1'b1, 32'h200); #1;
    chk("R7", "mispredict", {31'b0, mispredict}, 32'd1);
    chk("R8", "pred_next_pc", pred_next_pc, 32'h250);
    chk("R8", "pred_branched", {31'b0, pred_branched}, 32'd0);
    chk("R8", "pred_taken", {31'b0, pred_taken}, 32'd1);
    step();
    lookup("R3", 32'h100, 1'b1, 32'h250);
  endtask

  task automatic t_correct;
    ex_set(1'b1, 32'h100, 1'b1, 32'h250, 1'b1, 32'h250); #1;
    chk("R10", "taken correct", {31'b0, mispredict}, 32'd0);
    ex_set(1'b1, 32'h104, 1'b0, 32'h900, 1'b0, 32'h0); #1;
    chk("R10", "not-taken correct", {31'b0, mispredict}, 32'd0);
    ex_set(1'b1, 32'h104, 1'b0, 32'h900, 1'b0, 32'h444); #1;
    chk("R7", "not-taken ignores target", {31'b0, mispredict}, 32'd0);
    step();
  endtask

  task automatic t_taken_to_not;
    fetch_pc = 32'h800;
    ex_set(1'b1, 32'h100, 1'b0, 32'h250, 1'b1, 32'h250); #1;
    chk("R6", "mispredict", {31'b0, mispredict}, 32'd1);
    chk("R8", "redirect_pc", redirect_pc, 32'h104);
    chk("R8", "pred_next_pc", pred_next_pc, 32'h104);
    step();
    lookup("R3", 32'h100, 1'b0, 32'h104);
  endtask

  task automatic t_non_branch;
    fetch_pc = 32'h108;
    ex_set(1'b0, 32'h108, 1'b0, 32'h0, 1'b1, 32'h300); #1;
    chk("R9", "mispredict", {31'b0, mispredict}, 32'd0);
    chk("R9", "pred_next_pc", pred_next_pc, 32'h300);
    @(posedge clk); @(negedge clk);
    ex_set(1'b0, 32'h108, 1'b1, 32'h990, 1'b0, 32'h0); #1;
    chk("R9", "mispredict 2", {31'b0, mispredict}, 32'd0);
    step();
    lookup("R9", 32'h108, 1'b1, 32'h300);
  endtask

  initial begin
    #1;
    lookup("R1", 32'h0, 1'b0, 32'h4);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset_state();
    t_train_taken();
    t_alias();
    t_same_cycle();
    t_wrong_target();
    t_correct();
    t_taken_to_not();
    t_non_branch();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule